// File: doc/BRIEF.md
# Test-and-Set Ownership Semaphore Register

This block is one 32-bit register that host software and embedded firmware share to agree on who owns a shared resource. The low ten bits are plain ownership flags. Flags 0 to 4 are the software half and flags 5 to 9 are the firmware half. Flag n and flag n+5 guard the same resource:

| Pair | Resource |
|------|----------|
| 0 and 5 | nonvolatile configuration memory |
| 1 and 6 | PHY 0 |
| 2 and 7 | PHY 1 |
| 3 and 8 | shared control registers |
| 4 and 9 | flash |

Any write updates the flags. Hardware does not interlock them.

The top bit locks the register itself. When a strobed read finds this bit clear, the read returns 0 in that position and sets the bit in the same cycle. This is an atomic test-and-set that needs no locked bus transaction. The agent that read the 0 owns the lock until it writes 0 to the bit. The lock only advises: it does not block any access in hardware.

A side-effect-free view of the register contents is available for debug. A combinational error flag reports when both flags of any pair are 1.

Top module: `sema_reg`

## Requirements
- R1: After power-on reset, rd_data, peek_data and pair_err are all 0.
- R2: A write at the register address loads bits 9:0 from wr_data[9:0], whatever the state of the lock or of the other half. Flags read back exactly what was written.
- R3: A read at the register address that finds bit 31 at 0 returns 0 in bit 31 and leaves the bit at 1, so the next read returns 1 in bit 31.
- R4: A read that finds bit 31 at 1 returns 1 in bit 31 and leaves the bit at 1.
- R5: A write with wr_data[31]=0 clears bit 31. A write with wr_data[31]=1 leaves bit 31 unchanged, so only a read can set it.
- R6: When a read and a write hit in the same cycle:
  - the read returns the value from before that cycle;
  - the write is applied;
  - if the write carries 0 in bit 31, bit 31 ends at 0 even when the read found it at 0.
- R7: Bits 30:10 always read as 0, and writes to them are ignored.
- R8: pair_err is 1 exactly when flag n and flag n+5 are both 1 for some n in 0..4. The written value is stored anyway.
- R9: Strobes whose addr is not REG_ADDR change nothing in the register. Such a read returns 0. peek_data shows the contents without altering bit 31.
- R10: rd_data is updated one clock edge after a read strobe. It holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Access address; only REG_ADDR hits |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| peek_data | output | DATA_W | Current contents, with no read side effect |
| pair_err | output | 1 | Both flags of some pair are set |

## Verification
Every result is registered by exactly one clock edge:
- read data returned by a strobe;
- the lock bit and flags as shown on peek_data;
- the pair error derived from those flags.

The driver applies one access per cycle at the falling edge and pushes the expected values into a queue. The monitor pops each entry 2 ns after the following rising edge and compares all three outputs. Because the expected values are computed before the model updates, the pre-cycle read value in simultaneous read/write cases falls out of the same one-edge timing.

// File: rtl/sema_reg.sv
module sema_reg #(
  parameter int DATA_W   = 32,
  parameter int PAIRS    = 5,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] peek_data,
  output logic              pair_err
);
  localparam int FLAGS = 2 * PAIRS;
  localparam int LOCK  = DATA_W - 1;
  localparam int RSV   = DATA_W - 1 - FLAGS;

  logic [FLAGS-1:0] flags;
  logic             lock;
  logic             hit, rd_hit, wr_hit;

  assign hit    = (addr == REG_ADDR);
  assign rd_hit = rd_en && hit;
  assign wr_hit = wr_en && hit;

  assign peek_data = {lock, {RSV{1'b0}}, flags};
  assign pair_err  = |(flags[PAIRS-1:0] & flags[FLAGS-1:PAIRS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      lock    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rd_en)
        rd_data <= hit ? peek_data : '0;
      if (wr_hit)
        flags <= wr_data[FLAGS-1:0];
      if (wr_hit && !wr_data[LOCK])
        lock <= 1'b0;
      else if (rd_hit)
        lock <= 1'b1;
    end
  end

  p_read_sets_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit && !peek_data[LOCK]) |=> peek_data[LOCK]);

  p_lock_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !wr_hit && peek_data[LOCK]) |=> (peek_data[LOCK] && rd_data[LOCK]));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_data[LOCK]) |=> !peek_data[LOCK]);

  p_write_one_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[LOCK] && !rd_hit && !peek_data[LOCK]) |=> !peek_data[LOCK]);

  p_read_pre_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rd_data == $past(peek_data)));

  p_miss_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit || wr_hit) |=> $stable(peek_data));
endmodule

// File: tb/sema_reg_tb_top.sv
module sema_reg_tb_top;
  localparam logic [7:0] RA = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, peek_data;
  logic        pair_err;

  always #4 clk = ~clk;

  sema_reg dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .peek_data(peek_data), .pair_err(pair_err)
  );

  typedef struct {
    logic [31:0] rd;
    logic [31:0] pk;
    logic        er;
    string       tag;
  } item_t;

  item_t q[$];
  int vectors = 0, fails = 0;
  logic [9:0] m_flags = '0;
  logic       m_lock = 1'b0;
  logic [31:0] m_rd = '0;

  task automatic access(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
    item_t it;
    logic h;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    h = (a == RA);
    if (rd) m_rd = h ? {m_lock, 21'b0, m_flags} : 32'h0;
    if (wr && h && !d[31]) m_lock = 1'b0;
    else if (rd && h) m_lock = 1'b1;
    if (wr && h) m_flags = d[9:0];
    it.rd = m_rd;
    it.pk = {m_lock, 21'b0, m_flags};
    it.er = |(m_flags[4:0] & m_flags[9:5]);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(rd_data, it.rd, it.tag, "rd_data");
        cmp(peek_data, it.pk, it.tag, "peek_data");
        cmp({31'b0, pair_err}, {31'b0, it.er}, it.tag, "pair_err");
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    cmp(rd_data, 32'h0, "R1", "rd_data");
    cmp(peek_data, 32'h0, "R1", "peek_data");
    cmp({31'b0, pair_err}, 32'h0, "R1", "pair_err");
    rst_n = 1'b1;
    access(1, 0, RA, 0, "R3");
    access(1, 0, RA, 0, "R4");
    access(0, 1, RA, 32'h0, "R5");
    access(0, 1, RA, 32'h8000_0000, "R5");
    access(0, 1, RA, 32'hFFFF_FFFF, "R7");
    access(1, 0, RA, 0, "R7");
    access(0, 1, RA, 32'h8000_0015, "R2");
    access(1, 0, RA, 0, "R2");
    access(0, 1, RA, 32'h0000_0021, "R8");
    access(0, 1, RA, 32'h0000_0042, "R8");
    access(0, 1, RA, 32'h0000_0210, "R8");
    access(0, 1, RA, 32'h0000_0108, "R8");
    access(0, 1, RA, 32'h0000_0084, "R8");
    access(0, 1, RA, 32'h0000_03E0, "R2");
    access(1, 1, RA, 32'h0000_0005, "R6");
    access(1, 0, RA, 0, "R3");
    access(1, 1, RA, 32'h8000_0001, "R6");
    access(1, 0, 8'h41, 0, "R9");
    access(0, 1, 8'h44, 32'h0000_03FF, "R9");
    access(0, 1, RA, 32'h0000_0000, "R5");
    access(1, 0, 8'h00, 0, "R9");
    access(0, 0, RA, 0, "R9");
    access(1, 0, RA, 0, "R10");
    access(0, 0, RA, 0, "R10");
    access(0, 0, RA, 0, "R10");
    access(0, 1, RA, 32'h7FFF_FC1F, "R7");
    access(1, 0, RA, 0, "R4");
    idle();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule